// File: doc/BRIEF.md
# Flux-Pulse Byte Deserializer

This block rebuilds bytes from the pulses a floppy drive read head produces. Each flux-transition pulse stands for a 1 bit. A bit cell that passes with no pulse stands for a 0 bit. A free-running cell counter measures the time since the last bit was shifted in. When the counter reaches the timeout, the block shifts in a 0 by itself. The timeout is the bit-cell length plus a guard of two cycles. Two mode inputs select the bit-cell length: one chooses slow or fast bit rate, the other chooses the lower or higher reference clock.

A byte is framed only by its leading 1 bit. The shifter fills from the LSB side. As soon as bit 7 of the shifted value is 1, that value moves into the data register and the shifter starts again from zero. There is no separate bit counter. Bit 7 of the data register tells a reader that a byte is waiting. A bus-side clear request empties the data register. The shifter only runs while the two transfer-select inputs are both low.

Top module: `flux_deser`

## Requirements
- R1: After reset `data_o` is 0x00 and `valid_o` is 0.
- R2: `{clk_hi_i, fast_i}` selects the bit-cell length. 00 gives 24 cycles, 01 gives 12, 10 gives 32 and 11 gives 16. The timeout is this length plus 2.
- R3: In read mode, a clock edge with `flux_i` high shifts a 1 into the LSB of the shifter and restarts cell timing from that edge.
- R4: In read mode, if no flux pulse arrives, a 0 is shifted in on exactly the timeout-th edge after the last shift. That shift also restarts cell timing.
- R5: When a shift leaves bit 7 of the shifted value at 1, the value is written to `data_o` on that edge and the shifter restarts from zero. Bytes are assembled MSB first.
- R6: If a flux pulse and a timeout fall on the same edge, only a single 1 is shifted.
- R7: Read mode is `xfer_sel_i == 2'b00`. In any other setting, flux pulses are ignored and both the shifter and `data_o` hold their values.
- R8: Outside read mode the cell counter saturates instead of wrapping. After a long idle spell, the first edge back in read mode shifts a 0.
- R9: `clr_i` empties the data register on the next edge. A byte that completes on the same edge is loaded instead.
- R10: `valid_o` is 1 exactly when the data register holds a byte, that is, when bit 7 of `data_o` is 1.
- R11: The mode inputs are not latched. A change takes effect at the next timeout comparison, even in the middle of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flux_i | input | 1 | Flux-transition pulse, one cycle per transition |
| xfer_sel_i | input | 2 | Transfer select; 2'b00 is read mode |
| fast_i | input | 1 | 1 selects fast bit rate |
| clk_hi_i | input | 1 | 1 selects the higher reference clock |
| clr_i | input | 1 | Request to empty the data register |
| data_o | output | 8 | Data register |
| valid_o | output | 1 | Byte-waiting flag |

## Verification
The bench builds the block with its default parameters: an 8-bit shifter, cell lengths of 24, 12, 32 and 16, and a guard of 2. These defaults give a 6-bit cell counter that saturates at 63. A pulse placed exactly on the timeout edge therefore exercises the collision priority in every mode. An idle spell of 69 cycles outside read mode would wrap such a counter to a value below every timeout, so it tells saturation apart from wrapping. The short cell lengths also keep a whole byte under 300 cycles, which leaves room for every mode, a mid-byte mode change, and both clear orderings.

// File: rtl/flux_deser_pkg.sv
package flux_deser_pkg;

  localparam logic [1:0] XFER_READ = 2'b00;

  // Bit-cell length picked by {clk_hi, fast}
  function automatic int unsigned cell_len(
    input logic        clk_hi,
    input logic        fast,
    input int unsigned len_slow_lo,
    input int unsigned len_fast_lo,
    input int unsigned len_slow_hi,
    input int unsigned len_fast_hi
  );
    case ({clk_hi, fast})
      2'b00:   return len_slow_lo;
      2'b01:   return len_fast_lo;
      2'b10:   return len_slow_hi;
      default: return len_fast_hi;
    endcase
  endfunction

  function automatic int unsigned max4(
    input int unsigned a, input int unsigned b,
    input int unsigned c, input int unsigned d
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/flux_cell_timer.sv
module flux_cell_timer
  import flux_deser_pkg::*;
#(
  parameter int unsigned LEN_SLOW_LO = 24,
  parameter int unsigned LEN_FAST_LO = 12,
  parameter int unsigned LEN_SLOW_HI = 32,
  parameter int unsigned LEN_FAST_HI = 16,
  parameter int unsigned GUARD       = 2,
  parameter int unsigned CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_active,
  input  logic             flux,
  input  logic             fast,
  input  logic             clk_hi,
  output logic             shift_en,
  output logic             shift_bit,
  output logic             timeout,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] limit;
  logic             expired;

  // The limit follows the mode inputs live
  always_comb begin
    limit   = CNT_W'(cell_len(clk_hi, fast, LEN_SLOW_LO, LEN_FAST_LO,
                              LEN_SLOW_HI, LEN_FAST_HI) + GUARD);
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    expired = (cnt_inc >= limit);
    timeout   = rd_active && !flux && expired;
    shift_en  = rd_active && (flux || expired);
    shift_bit = flux;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (shift_en) cnt_q <= '0;
    else               cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/flux_shifter.sv
module flux_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic         byte_done,
  output logic [W-1:0] byte_val
);

  logic [W-1:0] sr_q;
  logic [W-1:0] shifted;

  always_comb begin
    shifted   = {sr_q[W-2:0], shift_bit};
    byte_done = shift_en && shifted[W-1];
    byte_val  = shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sr_q <= '0;
    else if (byte_done) sr_q <= '0;
    else if (shift_en)  sr_q <= shifted;
  end

endmodule

// File: rtl/flux_data_reg.sv
module flux_data_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (clr)  q <= '0;
  end

endmodule

// File: rtl/flux_deser.sv
module flux_deser
  import flux_deser_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LEN_SLOW_LO = 24,
  parameter int unsigned LEN_FAST_LO = 12,
  parameter int unsigned LEN_SLOW_HI = 32,
  parameter int unsigned LEN_FAST_HI = 16,
  parameter int unsigned GUARD       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flux_i,
  input  logic [1:0]        xfer_sel_i,
  input  logic              fast_i,
  input  logic              clk_hi_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam int unsigned MAX_LIM =
    max4(LEN_SLOW_LO, LEN_FAST_LO, LEN_SLOW_HI, LEN_FAST_HI) + GUARD;
  localparam int unsigned CNT_W = $clog2(MAX_LIM + 1);

  // Named internal events, visible to the bound checker
  logic              rd_active;
  logic              shift_en;
  logic              shift_bit;
  logic              timeout;
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;
  logic [CNT_W-1:0]  cell_cnt;

  assign rd_active = (xfer_sel_i == XFER_READ);

  flux_cell_timer #(
    .LEN_SLOW_LO (LEN_SLOW_LO),
    .LEN_FAST_LO (LEN_FAST_LO),
    .LEN_SLOW_HI (LEN_SLOW_HI),
    .LEN_FAST_HI (LEN_FAST_HI),
    .GUARD       (GUARD),
    .CNT_W       (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_active (rd_active),
    .flux      (flux_i),
    .fast      (fast_i),
    .clk_hi    (clk_hi_i),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .timeout   (timeout),
    .cnt_o     (cell_cnt)
  );

  flux_shifter #(.W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  flux_data_reg #(.W(DATA_W)) u_dreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (byte_done),
    .load_val (byte_val),
    .clr      (clr_i),
    .q        (data_o)
  );

  assign valid_o = data_o[DATA_W-1];

endmodule

// File: rtl/flux_deser_chk.sv
module flux_deser_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_active,
  input logic             flux_i,
  input logic             clr_i,
  input logic             shift_en,
  input logic             shift_bit,
  input logic             timeout,
  input logic             byte_done,
  input logic [CNT_W-1:0] cell_cnt,
  input logic [W-1:0]     data_o,
  input logic             valid_o
);

  // R6: a pulse on the timeout edge gives one shift of a 1
  a_r6_flux_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && flux_i) |-> (shift_en && shift_bit && !timeout));

  // R7: outside read mode the data register holds unless cleared
  a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_active && !clr_i) |=> $stable(data_o));

  // R5: a completed byte lands with its top bit set
  a_r5_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (data_o[W-1] && valid_o));

  // R9: a clear without a completing byte empties the register
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !byte_done) |=> (data_o == '0));

  // R8: idle counting never wraps
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |=> (cell_cnt >= $past(cell_cnt)));

  // R4: every shift restarts cell timing
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (cell_cnt == '0));

endmodule

bind flux_deser flux_deser_chk #(.W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_active (rd_active),
  .flux_i    (flux_i),
  .clr_i     (clr_i),
  .shift_en  (shift_en),
  .shift_bit (shift_bit),
  .timeout   (timeout),
  .byte_done (byte_done),
  .cell_cnt  (cell_cnt),
  .data_o    (data_o),
  .valid_o   (valid_o)
);

// File: tb/test_flux_deser.sv
module test_flux_deser;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flux_i = 1'b0;
  logic [1:0] xfer_sel_i = 2'b00;
  logic       fast_i = 1'b0;
  logic       clk_hi_i = 1'b0;
  logic       clr_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flux_deser i_flux_deser (
    .clk(clk), .rst_n(rst_n), .flux_i(flux_i), .xfer_sel_i(xfer_sel_i),
    .fast_i(fast_i), .clk_hi_i(clk_hi_i), .clr_i(clr_i),
    .data_o(data_o), .valid_o(valid_o)
  );

  // {clk_hi, fast, byte}
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 8'hD5}, {2'b01, 8'hAA}, {2'b10, 8'h96}, {2'b11, 8'hFF},
    {2'b00, 8'h80}, {2'b01, 8'hE7}, {2'b10, 8'h81}, {2'b11, 8'hB3}
  };

  // R2: timeout edges = cell length + 2
  function automatic int lim_of(input logic [1:0] m);
    int len;
    if (m == 2'b11)      len = 16;
    else if (m == 2'b10) len = 32;
    else if (m == 2'b01) len = 12;
    else                 len = 24;
    return len + 2;
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a negedge; consumes n edges with no pulse
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One-edge pulse, optionally with a clear on the same edge
  task automatic pulse(input logic with_clr);
    flux_i = 1'b1;
    clr_i  = with_clr;
    @(negedge clk);
    flux_i = 1'b0;
    clr_i  = 1'b0;
  endtask

  // Remaining bits after a shift, n bits from bit index top down
  task automatic send_tail(input logic [7:0] b, input int top, input int lim, input logic clr_last);
    for (int i = top; i >= 0; i--) begin
      if (b[i]) begin
        wait_n(lim / 2 - 1);
        pulse(clr_last && (i == 0));
      end else begin
        wait_n(lim);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int lim);
    pulse(1'b0);
    send_tail(b, 6, lim, 1'b0);
  endtask

  task automatic chk_byte(input string req, input logic [7:0] exp);
    check(req, {valid_o, data_o}, {exp[7], exp});
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk_byte("R1", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk_byte("R1", 8'h00);

    // Table walk: R2 R3 R4 R5 R10 across all four modes
    foreach (VEC[k]) begin
      {clk_hi_i, fast_i} = VEC[k][9:8];
      wait_n(3);
      send_byte(VEC[k][7:0], lim_of(VEC[k][9:8]));
      chk_byte("R2/R3/R4/R5", VEC[k][7:0]);
    end

    // R6: pulses exactly on each timeout edge give all ones
    {clk_hi_i, fast_i} = 2'b00;
    pulse(1'b0);
    for (int i = 0; i < 7; i++) begin
      wait_n(lim_of(2'b00) - 1);
      pulse(1'b0);
    end
    chk_byte("R6", 8'hFF);

    // R4 boundary: the edge before the timeout shifts nothing
    {clk_hi_i, fast_i} = 2'b01;
    pulse(1'b0);
    for (int i = 0; i < 7; i++) begin
      wait_n(lim_of(2'b01) - 2);
      pulse(1'b0);
    end
    chk_byte("R4", 8'hFF);

    // R9: clear alone empties the register, R10 flag drops
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    chk_byte("R9", 8'h00);
    check("R10", {8'h00, valid_o}, 9'h000);

    // R9: load beats clear on the same edge
    pulse(1'b0);
    send_tail(8'hA5, 6, lim_of(2'b01), 1'b1);
    chk_byte("R9", 8'hA5);

    // R7: pulses outside read mode are ignored
    xfer_sel_i = 2'b10;
    send_byte(8'hC3, lim_of(2'b01));
    chk_byte("R7", 8'hA5);
    xfer_sel_i = 2'b01;
    send_byte(8'h99, lim_of(2'b01));
    chk_byte("R7", 8'hA5);
    xfer_sel_i = 2'b00;
    wait_n(2);
    send_byte(8'h8E, lim_of(2'b01));
    chk_byte("R7", 8'h8E);

    // R8: long idle then return shifts a 0 on the first read edge
    pulse(1'b0);
    xfer_sel_i = 2'b11;
    wait_n(69);
    xfer_sel_i = 2'b00;
    wait_n(1);
    send_tail(8'hAD, 5, lim_of(2'b01), 1'b0);
    chk_byte("R8", {2'b10, 6'h2D});

    // R11: mid-byte mode change takes effect at once
    {clk_hi_i, fast_i} = 2'b00;
    wait_n(3);
    pulse(1'b0);
    {clk_hi_i, fast_i} = 2'b01;
    wait_n(lim_of(2'b01));
    send_tail(8'hB5, 5, lim_of(2'b01), 1'b0);
    chk_byte("R11", 8'hB5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule